// File: doc/BRIEF.md
# SDRAM Single-Bank Command Legality Tracker

This block watches the command bus of a synchronous DRAM and follows one bank of it. Each rising edge it decodes chip select, row strobe, column strobe and write enable, then applies the bank-select bits and A10. From these it keeps the bank's state: idle, opening a row, row open, a read or write burst that closes the row by itself, write recovery, or closing the row. A command that may not be issued in the current state raises a one-cycle error pulse and has no other effect.

The transient states end after counted cycles. The counts are the activate-to-column delay, the close-row time and the write-recovery time, all parameters. The burst length is captured from address bits 2..0 when a mode-register write is accepted. `state_o` always shows the state that the command at the next rising edge will be judged against, so a column command issued exactly the activate-to-column delay after the activate is accepted. One instance per bank is placed next to a memory controller or a bus monitor.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Commands are decoded as {cs_n,ras_n,cas_n,we_n}: cs_n=1 deselect, 0111 no-op, 0110 burst stop, 0101 read, 0100 write, 0011 activate, 0010 close row, 0001 refresh, 0000 mode write. Deselect and no-op never change the state and are never illegal.
- R2: After reset, state_o is 0 (idle), illegal_o is 0, ready_o is 1, and the burst length is 1.
- R3: Activate to this bank while idle gives state 1 (opening). The command at the TRCD-th edge after the activate is judged in state 2 (row open).
- R4: In state 2, read or write with a10=0 keeps state 2, and close row gives state 6. Read with a10=1 gives state 3 and write with a10=1 gives state 4. Activate, refresh and mode write are illegal.
- R5: State 3 lasts BL edges and then becomes state 6. In states 3 and 4 every command that reaches this bank, other than deselect and no-op, is illegal, including burst stop and the all-bank close.
- R6: State 4 lasts BL edges, then state 5 (write recovery) lasts TWR edges, then state 6 follows.
- R7: State 6 lasts TRP edges and then becomes idle. In states 5 and 6, burst stop and close row act as no-ops, while read, write, activate, refresh and mode write are illegal.
- R8: In state 1, only deselect, no-op and burst stop are legal.
- R9: Read, write, activate and close row with ba not equal to BANK_IDX are ignored. A close row with a10=1 applies to this bank whatever ba holds.
- R10: illegal_o is high for exactly the one cycle after each illegal command, back to back for consecutive ones. The state changes exactly as it would for a no-op, so timers keep running.
- R11: A mode write accepted in idle loads the burst length from mode_a: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives PAGE_BEATS, and any other code gives 1. An illegal mode write leaves the length unchanged.
- R12: ready_o is high exactly when state_o is 0 or 2.
- R13: In idle, read and write are illegal, while refresh, close row and burst stop are accepted and leave the state idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| a10 | input | 1 | Auto-close flag on read/write; all-bank flag on close row |
| mode_a | input | 3 | Address bits 2..0, read as the burst code on a mode write |
| state_o | output | 3 | Bank state code (0 idle … 6 closing) |
| illegal_o | output | 1 | One-cycle pulse after an illegal command |
| ready_o | output | 1 | Bank idle or row open |

## Verification
The two functions that can fall on the same edge are the expiry of a timed interval and the judging of a new command. The bench provokes this by issuing a command on exactly the edge where a countdown reaches zero: a read on the TRCD-th edge after activate, an activate on the last edge of the close-row time, and an illegal command on the last cycle of a transient state. The expected result is that the command is judged against the state that follows, while an illegal command still lets the timer advance, so the next state appears on schedule.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

   typedef enum logic [3:0] {
      C_DESL, C_NOP, C_BST, C_RD, C_WR, C_ACT, C_PRE, C_REF, C_MRS
   } cmd_e;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_OPEN = 3'd1,
      S_ROW  = 3'd2,
      S_RDAC = 3'd3,
      S_WRAC = 3'd4,
      S_WREC = 3'd5,
      S_CLOS = 3'd6
   } bst_e;

   function automatic logic nop_like(input cmd_e c);
      return (c == C_DESL) || (c == C_NOP);
   endfunction

   function automatic logic timed(input bst_e s);
      return (s == S_OPEN) || (s == S_RDAC) || (s == S_WRAC) ||
             (s == S_WREC) || (s == S_CLOS);
   endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_trk_pkg::*;
#(
   parameter int BA_W     = 2,
   parameter int BANK_IDX = 0
) (
   input  logic            cs_n,
   input  logic            ras_n,
   input  logic            cas_n,
   input  logic            we_n,
   input  logic [BA_W-1:0] ba,
   input  logic            a10,
   output cmd_e            cmd_o
);
   localparam logic [BA_W-1:0] MY_BA = BA_W'(BANK_IDX);

   cmd_e raw;
   logic hit;

   assign hit = (ba == MY_BA);

   always_comb begin
      raw = C_DESL;
      if (!cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b111:  raw = C_NOP;
            3'b110:  raw = C_BST;
            3'b101:  raw = C_RD;
            3'b100:  raw = C_WR;
            3'b011:  raw = C_ACT;
            3'b010:  raw = C_PRE;
            3'b001:  raw = C_REF;
            default: raw = C_MRS;
         endcase
      end
   end

   // bank filter: row/column commands only for this bank, close row also when all-bank
   always_comb begin
      cmd_o = raw;
      case (raw)
         C_RD, C_WR, C_ACT: if (!hit) cmd_o = C_NOP;
         C_PRE:             if (!hit && !a10) cmd_o = C_NOP;
         default:           cmd_o = raw;
      endcase
   end
endmodule

// File: rtl/sdram_burst_cfg.sv
module sdram_burst_cfg #(
   parameter int          LEN_W        = 8,
   parameter int          PAGE_BEATS   = 256,
   parameter bit          FULL_PAGE_EN = 1'b1,
   parameter logic [2:0]  RST_CODE     = 3'd0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [2:0]       code_in,
   output logic [LEN_W-1:0] bl_m1
);
   logic [2:0]       code_q;
   logic [LEN_W-1:0] page_m1;

   generate
      if (FULL_PAGE_EN) begin : g_page
         assign page_m1 = LEN_W'(PAGE_BEATS - 1);
      end else begin : g_nopage
         assign page_m1 = '0;
      end
      if (PAGE_BEATS < 8 || PAGE_BEATS > (1 << LEN_W)) begin : g_bad_page
         $error("sdram_burst_cfg: PAGE_BEATS out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    code_q <= RST_CODE;
      else if (load) code_q <= code_in;
   end

   always_comb begin
      case (code_q)
         3'd1:    bl_m1 = LEN_W'(1);
         3'd2:    bl_m1 = LEN_W'(3);
         3'd3:    bl_m1 = LEN_W'(7);
         3'd7:    bl_m1 = page_m1;
         default: bl_m1 = '0;
      endcase
   end

   // the burst code may only move on an accepted mode write
   p_bl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(code_q));
endmodule

// File: rtl/sdram_dwell_cnt.sv
module sdram_dwell_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // once expired the counter stays expired until reloaded (R10: timers keep running)
   p_zero_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_o && !load) |=> zero_o);
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
   import sdram_trk_pkg::*;
#(
   parameter int BA_W         = 2,
   parameter int BANK_IDX     = 0,
   parameter int TRCD         = 3,
   parameter int TRP          = 3,
   parameter int TWR          = 2,
   parameter int PAGE_BEATS   = 256,
   parameter bit FULL_PAGE_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            ras_n,
   input  logic            cas_n,
   input  logic            we_n,
   input  logic [BA_W-1:0] ba,
   input  logic            a10,
   input  logic [2:0]      mode_a,
   output logic [2:0]      state_o,
   output logic            illegal_o,
   output logic            ready_o
);
   localparam int MAX_T = (TRCD > TRP) ? ((TRCD > TWR) ? TRCD : TWR)
                                       : ((TRP > TWR) ? TRP : TWR);
   localparam int MAX_D = (MAX_T > PAGE_BEATS) ? MAX_T : PAGE_BEATS;
   localparam int CNT_W = (MAX_D > 8) ? $clog2(MAX_D) : 3;

   generate
      if (TRCD < 1 || TRP < 1 || TWR < 1) begin : g_bad_timing
         $error("sdram_bank_tracker: timing counts must be at least 1");
      end
      if (BANK_IDX < 0 || BANK_IDX >= (1 << BA_W)) begin : g_bad_bank
         $error("sdram_bank_tracker: BANK_IDX does not fit in BA_W");
      end
   endgenerate

   cmd_e             cmd;
   bst_e             st_q, eff, nxt;
   logic             zero, ill_c, ill_q, mrs_ok, ld;
   logic [CNT_W-1:0] bl_m1, ld_val;

   sdram_cmd_decode #(.BA_W(BA_W), .BANK_IDX(BANK_IDX)) u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .a10(a10), .cmd_o(cmd)
   );

   sdram_burst_cfg #(.LEN_W(CNT_W), .PAGE_BEATS(PAGE_BEATS),
                     .FULL_PAGE_EN(FULL_PAGE_EN), .RST_CODE(3'd0)) u_bl (
      .clk(clk), .rst_n(rst_n), .load(mrs_ok), .code_in(mode_a), .bl_m1(bl_m1)
   );

   sdram_dwell_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .zero_o(zero)
   );

   // state seen by the command at this edge: an expired interval already hands over
   always_comb begin
      eff = st_q;
      if (zero) begin
         case (st_q)
            S_OPEN:  eff = S_ROW;
            S_RDAC:  eff = S_CLOS;
            S_WRAC:  eff = S_WREC;
            S_WREC:  eff = S_CLOS;
            S_CLOS:  eff = S_IDLE;
            default: eff = st_q;
         endcase
      end
   end

   always_comb begin
      ill_c  = 1'b0;
      nxt    = eff;
      mrs_ok = 1'b0;
      case (eff)
         S_IDLE: begin
            case (cmd)
               C_RD, C_WR: ill_c  = 1'b1;
               C_ACT:      nxt    = S_OPEN;
               C_MRS:      mrs_ok = 1'b1;
               default:    ;
            endcase
         end
         S_OPEN: ill_c = !(nop_like(cmd) || cmd == C_BST);
         S_ROW: begin
            case (cmd)
               C_RD:                ill_c = 1'b0;
               C_WR:                ill_c = 1'b0;
               C_PRE:               nxt   = S_CLOS;
               C_ACT, C_REF, C_MRS: ill_c = 1'b1;
               default:             ;
            endcase
            if (cmd == C_RD && a10) nxt = S_RDAC;
            if (cmd == C_WR && a10) nxt = S_WRAC;
         end
         S_RDAC, S_WRAC: ill_c = !nop_like(cmd);
         default: begin
            case (cmd)
               C_RD, C_WR, C_ACT, C_REF, C_MRS: ill_c = 1'b1;
               default:                         ;
            endcase
         end
      endcase
   end

   always_comb begin
      case (nxt)
         S_OPEN:         ld_val = CNT_W'(TRCD - 1);
         S_RDAC, S_WRAC: ld_val = bl_m1;
         S_WREC:         ld_val = CNT_W'(TWR - 1);
         S_CLOS:         ld_val = CNT_W'(TRP - 1);
         default:        ld_val = '0;
      endcase
   end
   assign ld = (nxt != st_q) && timed(nxt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= S_IDLE;
         ill_q <= 1'b0;
      end else begin
         st_q  <= nxt;
         ill_q <= ill_c;
      end
   end

   assign state_o   = eff;
   assign illegal_o = ill_q;
   assign ready_o   = (eff == S_IDLE) || (eff == S_ROW);

   p_act_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eff == S_IDLE && cmd == C_ACT) |=> st_q == S_OPEN);

   p_ill_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ill_c && (eff == S_IDLE || eff == S_ROW)) |=> st_q == $past(eff));

   p_rdac_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_RDAC && !zero) |=> st_q == S_RDAC);

   p_rec_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == S_WREC) |-> $past(st_q) == S_WRAC);
endmodule

// File: tb/sim_sdram_bank_tracker.sv
module sim_sdram_bank_tracker;
   localparam logic [3:0] K_DESL = 4'b1111, K_NOP = 4'b0111, K_BST = 4'b0110,
                          K_RD = 4'b0101, K_WR = 4'b0100, K_ACT = 4'b0011,
                          K_PRE = 4'b0010, K_REF = 4'b0001, K_MRS = 4'b0000;

   typedef struct packed {
      logic [3:0] k;
      logic [1:0] ba;
      logic       a10;
      logic [2:0] bl;
      logic [2:0] st;
      logic       ill;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 42;
   // bank under test is 1; TRCD=2, TRP=2, TWR=2, PAGE_BEATS=16
   localparam vec_t TBL [NV] = '{
      '{K_NOP, 2'd1,1'b0,3'd0,3'd0,1'b0,4'd1},   // R1
      '{K_RD,  2'd1,1'b0,3'd0,3'd0,1'b1,4'd13},  // R13 read in idle
      '{K_MRS, 2'd0,1'b0,3'd2,3'd0,1'b0,4'd11},  // R11 BL=4
      '{K_ACT, 2'd0,1'b0,3'd0,3'd0,1'b0,4'd9},   // R9 other bank
      '{K_ACT, 2'd1,1'b0,3'd0,3'd1,1'b0,4'd3},   // R3
      '{K_RD,  2'd1,1'b0,3'd0,3'd2,1'b1,4'd3},   // R3 too early, timer runs
      '{K_RD,  2'd1,1'b0,3'd0,3'd2,1'b0,4'd4},   // R4
      '{K_REF, 2'd0,1'b0,3'd0,3'd2,1'b1,4'd4},   // R4
      '{K_RD,  2'd1,1'b1,3'd0,3'd3,1'b0,4'd5},   // R5
      '{K_PRE, 2'd0,1'b0,3'd0,3'd3,1'b0,4'd9},   // R9 single close elsewhere
      '{K_BST, 2'd1,1'b0,3'd0,3'd3,1'b1,4'd5},   // R5
      '{K_DESL,2'd1,1'b0,3'd0,3'd6,1'b0,4'd1},   // R1 / burst ends
      '{K_NOP, 2'd1,1'b0,3'd0,3'd6,1'b0,4'd5},   // R5
      '{K_ACT, 2'd1,1'b0,3'd0,3'd0,1'b1,4'd7},   // R7 illegal on last cycle
      '{K_ACT, 2'd1,1'b0,3'd0,3'd1,1'b0,4'd3},   // R3
      '{K_PRE, 2'd1,1'b1,3'd0,3'd2,1'b1,4'd8},   // R8
      '{K_WR,  2'd1,1'b1,3'd0,3'd4,1'b0,4'd6},   // R6
      '{K_NOP, 2'd1,1'b0,3'd0,3'd4,1'b0,4'd6},   // R6
      '{K_PRE, 2'd0,1'b1,3'd0,3'd4,1'b1,4'd6},   // R6 all-bank close illegal
      '{K_NOP, 2'd1,1'b0,3'd0,3'd5,1'b0,4'd6},   // R6
      '{K_NOP, 2'd1,1'b0,3'd0,3'd5,1'b0,4'd6},   // R6
      '{K_BST, 2'd1,1'b0,3'd0,3'd6,1'b0,4'd7},   // R7
      '{K_PRE, 2'd1,1'b0,3'd0,3'd6,1'b0,4'd7},   // R7
      '{K_NOP, 2'd1,1'b0,3'd0,3'd0,1'b0,4'd7},   // R7
      '{K_MRS, 2'd0,1'b0,3'd7,3'd0,1'b0,4'd11},  // R11 full page
      '{K_REF, 2'd0,1'b0,3'd0,3'd0,1'b0,4'd13},  // R13
      '{K_PRE, 2'd1,1'b0,3'd0,3'd0,1'b0,4'd13},  // R13
      '{K_ACT, 2'd1,1'b0,3'd0,3'd1,1'b0,4'd3},   // R3
      '{K_NOP, 2'd1,1'b0,3'd0,3'd2,1'b0,4'd3},   // R3
      '{K_PRE, 2'd0,1'b1,3'd0,3'd6,1'b0,4'd9},   // R9 all-bank close
      '{K_NOP, 2'd1,1'b0,3'd0,3'd0,1'b0,4'd7},   // R7
      '{K_WR,  2'd1,1'b0,3'd0,3'd0,1'b1,4'd13},  // R13
      '{K_MRS, 2'd0,1'b0,3'd1,3'd0,1'b0,4'd11},  // R11 BL=2
      '{K_ACT, 2'd1,1'b0,3'd0,3'd1,1'b0,4'd3},   // R3
      '{K_NOP, 2'd1,1'b0,3'd0,3'd2,1'b0,4'd3},   // R3
      '{K_MRS, 2'd0,1'b0,3'd3,3'd2,1'b1,4'd4},   // R4
      '{K_ACT, 2'd1,1'b0,3'd0,3'd2,1'b1,4'd10},  // R10 back-to-back pulse
      '{K_WR,  2'd1,1'b0,3'd0,3'd2,1'b0,4'd4},   // R4
      '{K_RD,  2'd1,1'b1,3'd0,3'd3,1'b0,4'd11},  // R11 BL still 2
      '{K_NOP, 2'd1,1'b0,3'd0,3'd6,1'b0,4'd11},  // R11
      '{K_NOP, 2'd1,1'b0,3'd0,3'd6,1'b0,4'd7},   // R7
      '{K_NOP, 2'd1,1'b0,3'd0,3'd0,1'b0,4'd7}    // R7
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cs_n, ras_n, cas_n, we_n, a10;
   logic [1:0] ba;
   logic [2:0] mode_a, state_o;
   logic       illegal_o, ready_o;
   int         checks = 0, errors = 0;

   always #5 clk = ~clk;

   sdram_bank_tracker #(.BA_W(2), .BANK_IDX(1), .TRCD(2), .TRP(2), .TWR(2),
                        .PAGE_BEATS(16), .FULL_PAGE_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .a10(a10), .mode_a(mode_a),
      .state_o(state_o), .illegal_o(illegal_o), .ready_o(ready_o)
   );

   task automatic put(input logic [3:0] k, input logic [1:0] b,
                      input logic f, input logic [2:0] m);
      {cs_n, ras_n, cas_n, we_n} = k;
      ba = b; a10 = f; mode_a = m;
   endtask

   task automatic chk(input string tag, input logic [2:0] est, input logic eill);
      logic erdy;
      erdy = (est == 3'd0) || (est == 3'd2);
      checks++;
      if (state_o !== est || illegal_o !== eill) begin
         errors++;
         $display("FAIL %s: state=%0d illegal=%0b expected state=%0d illegal=%0b",
                  tag, state_o, illegal_o, est, eill);
      end
      if (ready_o !== erdy) begin
         errors++;
         $display("FAIL R12 (%s): ready=%0b expected %0b", tag, ready_o, erdy);
      end
   endtask

   task automatic step(input logic [3:0] k, input logic [1:0] b, input logic f,
                       input logic [2:0] m, input logic [2:0] est, input logic eill,
                       input string tag);
      put(k, b, f, m);
      @(negedge clk);
      chk(tag, est, eill);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      put(K_DESL, 2'd0, 1'b0, 3'd0);
      repeat (3) @(negedge clk);
      chk("R2 reset", 3'd0, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         put(TBL[i].k, TBL[i].ba, TBL[i].a10, TBL[i].bl);
         @(negedge clk);
         chk($sformatf("R%0d vec%0d", TBL[i].rq, i), TBL[i].st, TBL[i].ill);
      end

      // R11 full-page burst of 16 beats
      step(K_MRS, 2'd0, 1'b0, 3'd7, 3'd0, 1'b0, "R11 page mode");
      step(K_ACT, 2'd1, 1'b0, 3'd0, 3'd1, 1'b0, "R3");
      step(K_NOP, 2'd1, 1'b0, 3'd0, 3'd2, 1'b0, "R3");
      step(K_RD,  2'd1, 1'b1, 3'd0, 3'd3, 1'b0, "R5 page read");
      for (int j = 0; j < 14; j++) begin
         put(K_NOP, 2'd1, 1'b0, 3'd0);
         @(negedge clk);
      end
      chk("R11 page beat 15", 3'd3, 1'b0);
      step(K_NOP, 2'd1, 1'b0, 3'd0, 3'd6, 1'b0, "R11 page end");
      step(K_NOP, 2'd1, 1'b0, 3'd0, 3'd6, 1'b0, "R7");
      step(K_NOP, 2'd1, 1'b0, 3'd0, 3'd0, 1'b0, "R7");

      // R2 reset in mid-state restores idle and burst length 1
      step(K_ACT, 2'd1, 1'b0, 3'd0, 3'd1, 1'b0, "R3");
      put(K_DESL, 2'd0, 1'b0, 3'd0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2 mid reset", 3'd0, 1'b0);
      rst_n = 1'b1;
      step(K_ACT, 2'd1, 1'b0, 3'd0, 3'd1, 1'b0, "R3");
      step(K_NOP, 2'd1, 1'b0, 3'd0, 3'd2, 1'b0, "R3");
      step(K_RD,  2'd1, 1'b1, 3'd0, 3'd6, 1'b0, "R2 BL back to 1");
      step(K_NOP, 2'd1, 1'b0, 3'd0, 3'd6, 1'b0, "R7");
      step(K_NOP, 2'd1, 1'b0, 3'd0, 3'd0, 1'b0, "R7");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule